// File: doc/BRIEF.md
# Bridge System-Error Signalling Control

This block decides when a bus-to-bus bridge pulls its active-low system-error line on the primary side. Five error causes arrive as single-cycle pulses on one vector: a parity error that the destination bus reports against a posted write, expiry of the primary or secondary discard timer, and expiry of the primary or secondary retry counter. Each cause has its own disable bit in an 8-bit read/write mask register. The system-error enable from the command register, and the discard-error enable from the bridge control register, come in as level inputs and act as global qualifiers.

For every qualifying event the block lowers `serrN` for one clock and sets a sticky "signalled system error" status flag. The timer and retry causes always record a sticky flag in a timer status byte, whether or not the error is reported. Both discard-timer causes always ask the transaction logic to drop the pending delayed transaction, and an unmasked posted-write parity error does the same. Software reads and writes the mask and the two status bytes through a plain strobe port. Status flags are cleared by writing 1.

Top module: `serr_report`

## Requirements
- R1: After reset the mask register, the status flag and the timer status bits are 0, `serrN` is 1 and `discardDly` is 0.
- R2: The mask register is at byte address 0x5C. Bits 4:0 are read/write and bits 7:5 always read 0, whatever is written. A byte address that matches no register reads 0.
- R3: An event on `errEvt[4]` (posted-write parity error) with mask bit 4 clear and `cmdSerrEn` high drives `serrN` low in the cycle after the event. It also sets the status flag, which reads as bit 6 of byte address 0x07. `bctlSerrEn` has no effect on this cause.
- R4: An event on `errEvt[4]` with mask bit 4 clear pulses `discardDly` in the next cycle, whatever `cmdSerrEn` is. With mask bit 4 set, the event gives no system-error pulse, no discard and no status flag.
- R5: An event on `errEvt[3]` (primary discard timer) or `errEvt[2]` (secondary discard timer) lowers `serrN` and sets the status flag only when its own mask bit (3 or 2) is clear and both `cmdSerrEn` and `bctlSerrEn` are high.
- R6: An event on `errEvt[3]` or `errEvt[2]` always pulses `discardDly` in the next cycle. It always sets bit 3 or bit 2 of the timer status byte at address 0x5E, whatever the mask and the enables are.
- R7: An event on `errEvt[1]` (primary retry expiry) or `errEvt[0]` (secondary retry expiry) uses the same qualification as R5 with mask bit 1 or 0. It always sets timer status bit 1 or 0, and it never pulses `discardDly`.
- R8: A set mask bit suppresses the system error for its own cause only. The other causes still report.
- R9: The status flag and the timer status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a set and a clear land in the same cycle, the set wins.
- R10: Events in one cycle, whether one or several qualify, give a single low cycle on `serrN`. `serrN` returns high in the following cycle unless a new qualifying event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errEvt | input | 5 | Error event pulses: bit 4 posted-write parity, bit 3 primary discard, bit 2 secondary discard, bit 1 primary retry, bit 0 secondary retry |
| cmdSerrEn | input | 1 | System-error enable from the command register |
| bctlSerrEn | input | 1 | Discard/retry system-error enable from the bridge control register |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| serrN | output | 1 | Active-low system-error output, one clock per qualifying cycle |
| discardDly | output | 1 | One-cycle request to drop the pending delayed transaction |

## Verification
Each cause is fired alone while the mask bit, `cmdSerrEn` and `bctlSerrEn` are swept. This separates the parity cause, which ignores the bridge-control enable, from the timer and retry causes, which need both enables. Running with the mask set and the enables low shows that the discard request and the timer status do not depend on reporting. A mask that leaves only one cause open shows that each disable bit acts alone. Firing all causes at once checks that they merge into one pulse. A write-one-clear that lands in the same cycle as a new event checks that the set takes priority.

// File: rtl/serr_pkg.sv
package serr_pkg;
  localparam int NUM_CAUSE = 5;
  localparam int TMR_BITS  = 4;

  // cause positions inside errEvt and the mask register
  localparam int C_PERR   = 4;
  localparam int C_PDISC  = 3;
  localparam int C_SDISC  = 2;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MASK = 2'd1,
    RD_STAT = 2'd2,
    RD_TMR  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic                maskWr;
    logic                sysSet;
    logic                sysClr;
    logic [TMR_BITS-1:0] tmrSet;
    logic [TMR_BITS-1:0] tmrClr;
    logic                serrFire;
    logic                discardFire;
    rdSel_e              rdSel;
  } serrStrobe_t;
endpackage

// File: rtl/serr_ctrl.sv
module serr_ctrl
  import serr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  MASK_OFS  = 8'h5C,
  parameter logic [7:0]  STAT_OFS  = 8'h07,
  parameter logic [7:0]  TMR_OFS   = 8'h5E,
  parameter int          SYS_BIT   = 6
) (
  input  logic [NUM_CAUSE-1:0] errEvt,
  input  logic                 cmdSerrEn,
  input  logic                 bctlSerrEn,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [DATA_W-1:0]    maskQ,
  output serrStrobe_t          strb
);
  logic [NUM_CAUSE-1:0] qual;
  logic hitMask, hitStat, hitTmr;

  assign hitMask = (regAddr == ADDR_W'(MASK_OFS));
  assign hitStat = (regAddr == ADDR_W'(STAT_OFS));
  assign hitTmr  = (regAddr == ADDR_W'(TMR_OFS));

  // per-cause qualification: the parity cause needs only the command enable
  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_qual
    if (i == C_PERR) begin : g_par
      assign qual[i] = errEvt[i] & ~maskQ[i] & cmdSerrEn;
    end else begin : g_tmr
      assign qual[i] = errEvt[i] & ~maskQ[i] & cmdSerrEn & bctlSerrEn;
    end
  end

  always_comb begin
    strb             = '0;
    strb.maskWr      = regWr & hitMask;
    strb.sysClr      = regWr & hitStat & regWrData[SYS_BIT];
    strb.tmrClr      = (regWr & hitTmr) ? regWrData[TMR_BITS-1:0] : '0;
    strb.sysSet      = |qual;
    strb.serrFire    = |qual;
    strb.tmrSet      = errEvt[TMR_BITS-1:0];
    strb.discardFire = errEvt[C_PDISC] | errEvt[C_SDISC] |
                       (errEvt[C_PERR] & ~maskQ[C_PERR]);
    if (hitMask)      strb.rdSel = RD_MASK;
    else if (hitStat) strb.rdSel = RD_STAT;
    else if (hitTmr)  strb.rdSel = RD_TMR;
    else              strb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/serr_dpath.sv
module serr_dpath
  import serr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SYS_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  serrStrobe_t       strb,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] regRdData,
  output logic              serrN,
  output logic              discardDly
);
  localparam logic [DATA_W-1:0] WR_MASK = DATA_W'((1 << NUM_CAUSE) - 1);

  logic                sysStatQ;
  logic [TMR_BITS-1:0] tmrStatQ;
  logic                serrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ      <= '0;
      sysStatQ   <= 1'b0;
      tmrStatQ   <= '0;
      serrQ      <= 1'b0;
      discardDly <= 1'b0;
    end else begin
      if (strb.maskWr) maskQ <= regWrData & WR_MASK;
      sysStatQ   <= strb.sysSet | (sysStatQ & ~strb.sysClr);
      serrQ      <= strb.serrFire;
      discardDly <= strb.discardFire;
    end
  end

  for (genvar k = 0; k < TMR_BITS; k++) begin : g_tmr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tmrStatQ[k] <= 1'b0;
      else       tmrStatQ[k] <= strb.tmrSet[k] | (tmrStatQ[k] & ~strb.tmrClr[k]);
    end
  end

  assign serrN = ~serrQ;

  always_comb begin
    regRdData = '0;
    unique case (strb.rdSel)
      RD_MASK: regRdData = maskQ;
      RD_STAT: regRdData[SYS_BIT] = sysStatQ;
      RD_TMR:  regRdData[TMR_BITS-1:0] = tmrStatQ;
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/serr_report.sv
module serr_report
  import serr_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] MASK_OFS = 8'h5C,
  parameter logic [7:0] STAT_OFS = 8'h07,
  parameter logic [7:0] TMR_OFS  = 8'h5E,
  parameter int         SYS_BIT  = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CAUSE-1:0] errEvt,
  input  logic                 cmdSerrEn,
  input  logic                 bctlSerrEn,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 serrN,
  output logic                 discardDly
);
  serrStrobe_t       strb;
  logic [DATA_W-1:0] maskQ;

  serr_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_OFS(MASK_OFS),
    .STAT_OFS(STAT_OFS), .TMR_OFS(TMR_OFS), .SYS_BIT(SYS_BIT)
  ) u_ctrl (
    .errEvt(errEvt), .cmdSerrEn(cmdSerrEn), .bctlSerrEn(bctlSerrEn),
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .maskQ(maskQ), .strb(strb)
  );

  serr_dpath #(.DATA_W(DATA_W), .SYS_BIT(SYS_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .maskQ(maskQ), .regRdData(regRdData), .serrN(serrN),
    .discardDly(discardDly)
  );
endmodule

// File: rtl/serr_report_chk.sv
module serr_report_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        errEvt,
  input logic              cmdSerrEn,
  input logic              bctlSerrEn,
  input logic [DATA_W-1:0] maskQ,
  input logic              serrN,
  input logic              discardDly
);
  logic anyQual;
  assign anyQual = cmdSerrEn &
                   ((errEvt[4] & ~maskQ[4]) |
                    (bctlSerrEn & |(errEvt[3:0] & ~maskQ[3:0])));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    maskQ[7:5] == 3'b000);

  a_r3_perr_serr: assert property (@(posedge clk) disable iff (!rstN)
    (errEvt[4] && !maskQ[4] && cmdSerrEn) |=> !serrN);

  a_r4_perr_discard: assert property (@(posedge clk) disable iff (!rstN)
    (errEvt[4] && !maskQ[4]) |=> discardDly);

  a_r6_timer_discard: assert property (@(posedge clk) disable iff (!rstN)
    (errEvt[3] || errEvt[2]) |=> discardDly);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !serrN |-> $past(anyQual));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (!serrN && !anyQual) |=> serrN);
endmodule

bind serr_report serr_report_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .errEvt(errEvt), .cmdSerrEn(cmdSerrEn),
  .bctlSerrEn(bctlSerrEn), .maskQ(maskQ), .serrN(serrN),
  .discardDly(discardDly)
);

// File: tb/sim_serr_report.sv
module sim_serr_report;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] errEvt = '0;
  logic       cmdSerrEn = 1'b0;
  logic       bctlSerrEn = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       serrN;
  logic       discardDly;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serr_report u0 (
    .clk(clk), .rstN(rstN), .errEvt(errEvt), .cmdSerrEn(cmdSerrEn),
    .bctlSerrEn(bctlSerrEn), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .serrN(serrN),
    .discardDly(discardDly)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, regRdData, exp);
  endtask

  // fire one event cycle, check the response cycle and the return to idle
  task automatic fire(input string req, input logic [4:0] ev, input logic cmd,
                      input logic bctl, input logic expSerr, input logic expDisc);
    @(negedge clk);
    cmdSerrEn = cmd; bctlSerrEn = bctl; errEvt = ev;
    @(negedge clk);
    errEvt = '0;
    chk({req, " serrN"}, {7'b0, serrN}, {7'b0, ~expSerr});
    chk({req, " discard"}, {7'b0, discardDly}, {7'b0, expDisc});
    @(negedge clk);
    chk({req, " idle"}, {7'b0, serrN}, 8'h01);
  endtask

  task automatic t_reset;
    chk("R1 serrN", {7'b0, serrN}, 8'h01);
    chk("R1 discard", {7'b0, discardDly}, 8'h00);
    rdChk("R1 mask", 8'h5C, 8'h00);
    rdChk("R1 stat", 8'h07, 8'h00);
    rdChk("R1 tmr", 8'h5E, 8'h00);
  endtask

  task automatic t_mask_rw;
    wrReg(8'h5C, 8'hFF);
    rdChk("R2 writable", 8'h5C, 8'h1F);
    wrReg(8'h5C, 8'hE0);
    rdChk("R2 reserved", 8'h5C, 8'h00);
    rdChk("R2 unmapped", 8'h10, 8'h00);
  endtask

  task automatic t_perr;
    wrReg(8'h5C, 8'h00);
    fire("R3 perr", 5'b10000, 1'b1, 1'b0, 1'b1, 1'b1);
    rdChk("R3 stat", 8'h07, 8'h40);
    wrReg(8'h07, 8'h40);
    rdChk("R9 stat clr", 8'h07, 8'h00);
    fire("R4 perr cmd off", 5'b10000, 1'b0, 1'b1, 1'b0, 1'b1);
    rdChk("R4 stat cmd off", 8'h07, 8'h00);
    wrReg(8'h5C, 8'h10);
    fire("R4 perr masked", 5'b10000, 1'b1, 1'b1, 1'b0, 1'b0);
    rdChk("R4 stat masked", 8'h07, 8'h00);
  endtask

  task automatic t_discard;
    wrReg(8'h5C, 8'h00);
    fire("R5 pdisc", 5'b01000, 1'b1, 1'b1, 1'b1, 1'b1);
    rdChk("R6 tmr pdisc", 8'h5E, 8'h08);
    rdChk("R5 stat", 8'h07, 8'h40);
    wrReg(8'h07, 8'h40);
    fire("R5 sdisc bctl off", 5'b00100, 1'b1, 1'b0, 1'b0, 1'b1);
    rdChk("R6 tmr sdisc", 8'h5E, 8'h0C);
    rdChk("R5 stat bctl off", 8'h07, 8'h00);
    wrReg(8'h5C, 8'h08);
    fire("R6 pdisc masked", 5'b01000, 1'b1, 1'b1, 1'b0, 1'b1);
    wrReg(8'h5E, 8'h0C);
    rdChk("R9 tmr clr", 8'h5E, 8'h00);
  endtask

  task automatic t_retry;
    wrReg(8'h5C, 8'h00);
    fire("R7 pretry", 5'b00010, 1'b1, 1'b1, 1'b1, 1'b0);
    fire("R7 sretry cmd off", 5'b00001, 1'b0, 1'b1, 1'b0, 1'b0);
    rdChk("R7 tmr", 8'h5E, 8'h03);
  endtask

  task automatic t_own_only;
    wrReg(8'h5C, 8'h1E);
    fire("R8 open cause", 5'b00001, 1'b1, 1'b1, 1'b1, 1'b0);
    fire("R8 masked cause", 5'b00010, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_sticky;
    wrReg(8'h5E, 8'h00);
    rdChk("R9 write zero", 8'h5E, 8'h03);
    wrReg(8'h5E, 8'h01);
    rdChk("R9 partial clr", 8'h5E, 8'h02);
    // clear and set of bit 3 in the same cycle: set wins
    @(negedge clk);
    regWr = 1'b1; regAddr = 8'h5E; regWrData = 8'h0F; errEvt = 5'b01000;
    @(negedge clk);
    regWr = 1'b0; errEvt = '0;
    rdChk("R9 set wins", 8'h5E, 8'h08);
  endtask

  task automatic t_simul;
    wrReg(8'h5C, 8'h00);
    fire("R10 all causes", 5'b11111, 1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    errEvt = 5'b00010;
    @(negedge clk);
    errEvt = 5'b00001;
    @(negedge clk);
    errEvt = '0;
    chk("R10 back to back", {7'b0, serrN}, 8'h00);
    @(negedge clk);
    chk("R10 release", {7'b0, serrN}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_rw();
    t_perr();
    t_discard();
    t_retry();
    t_own_only();
    t_sticky();
    t_simul();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule